// File: doc/BRIEF.md
# Emulated-Clock Write Port RAM

This block is a small RAM whose write ports belong to slower clock domains that are not real clocks inside the block. Each write clock arrives as an ordinary data bit, sampled by one fast global clock, and the block finds its active edge by comparing the present sample with the one taken a global cycle earlier. Write enable, address and data are held for one global cycle, so the array sees the values present just before the emulated edge. This matches what a flop clocked by that edge would have captured. Everything, including the storage, then runs on the single fast clock.

Each write port has its own edge polarity. The write enable has one bit per data bit. When several ports write in the same global cycle, they are applied in port order. Reading is asynchronous: the read data follows the read address combinationally. A configuration that asks for a registered read port stops elaboration with an error, because a registered read has no meaning once every clock is a sampled signal.

Top module: `emu_wport_ram`

## Requirements
- R1: `rd_data` equals the stored word at `rd_addr` within the same global cycle, with no register on the read path.
- R2: A port whose bit in `WR_POL` is 1 (rising) writes only in a global cycle where its write-clock sample is 1 and the previous sample was 0. A high level held or a 1-to-0 change writes nothing.
- R3: A port whose bit in `WR_POL` is 0 (falling) writes only in a global cycle where its sample is 0 and the previous sample was 1. A 0-to-1 change writes nothing.
- R4: The enable, address and data used by a write are the values sampled one global cycle before the edge cycle. Values that change at the same moment as the write-clock sample are not used.
- R5: The write enable works per bit. Bit k of a port's enable set to 1 updates bit k of the addressed word, and bits whose enable is 0 keep their value.
- R6: With no write-clock edge detected on any port, the array keeps its contents whatever the enables, addresses and data do.
- R7: During reset the previous-sample register of a rising port holds 1, and that of a falling port holds 0. No write occurs while reset is active. A write clock sitting at that level when reset ends produces no write.
- R8: When several ports write the same address in one global cycle, the higher-indexed port wins on every bit both enable. On the other bits, each port's own enabled bits take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast global clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the write-clock sample registers |
| wr_clk_s | input | NUM_WR | Sampled emulated write clock, one bit per port |
| wr_en | input | NUM_WR*DATA_W | Per-bit write enable, port p at bits [p*DATA_W +: DATA_W] |
| wr_addr | input | NUM_WR*ADDR_BITS | Write address, port p at bits [p*ADDR_BITS +: ADDR_BITS] |
| wr_data | input | NUM_WR*DATA_W | Write data, port p at bits [p*DATA_W +: DATA_W] |
| rd_addr | input | ADDR_BITS | Read address |
| rd_data | output | DATA_W | Stored word at rd_addr, combinational |

## Verification
The hardest case to reach from the ports is a global cycle in which a rising port and a falling port both see their edges at once. Both must hit the same word, with overlapping but unequal enables. The bench gets there by parking the two write clocks at opposite levels and flipping both in the same global cycle. A second hard case is an input that changes at the same moment as the edge sample. The bench changes address, data and enable together with the write-clock bit. Both the intended word and the would-be word are then read back to confirm that the staged values were used.

// File: rtl/emw_pkg.sv
package emw_pkg;

  // Polarity code of one write port: 1 = active on 0->1, 0 = active on 1->0.
  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } wr_pol_e;

  // Level the previous-sample register takes in reset so that a clock
  // parked at its inactive level cannot look like an edge.
  function automatic logic idle_level(input wr_pol_e pol);
    return (pol == POL_RISE) ? 1'b1 : 1'b0;
  endfunction

  // Edge test on the pair {current sample, previous sample}.
  function automatic logic edge_seen(input logic cur, input logic prev,
                                     input wr_pol_e pol);
    logic [1:0] pair;
    pair = {cur, prev};
    return (pol == POL_RISE) ? (pair == 2'b10) : (pair == 2'b01);
  endfunction

endpackage

// File: rtl/emw_edge_det.sv
module emw_edge_det
  import emw_pkg::*;
#(
  parameter wr_pol_e POL = POL_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  output logic edge_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= idle_level(POL);
    else        prev_q <= smp;
  end

  assign edge_o = edge_seen(smp, prev_q, POL);

endmodule

// File: rtl/emw_wr_stage.sv
module emw_wr_stage #(
  parameter int DATA_W    = 8,
  parameter int ADDR_BITS = 4
) (
  input  logic                 clk,
  input  logic [DATA_W-1:0]    en_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 edge_i,
  output logic [DATA_W-1:0]    en_o,
  output logic [ADDR_BITS-1:0] addr_o,
  output logic [DATA_W-1:0]    data_o
);

  logic [DATA_W-1:0]    en_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic [DATA_W-1:0]    data_q;

  // Plain staging flops: they behave like the input side of a flop on the
  // emulated clock and carry no reset of their own.
  always_ff @(posedge clk) begin
    en_q   <= en_i;
    addr_q <= addr_i;
    data_q <= data_i;
  end

  assign en_o   = edge_i ? en_q : '0;
  assign addr_o = addr_q;
  assign data_o = data_q;

endmodule

// File: rtl/emw_array.sv
module emw_array #(
  parameter int DATA_W    = 8,
  parameter int ADDR_BITS = 4,
  parameter int NUM_WR    = 2
) (
  input  logic                        clk,
  input  logic [NUM_WR*DATA_W-1:0]    wen,
  input  logic [NUM_WR*ADDR_BITS-1:0] waddr,
  input  logic [NUM_WR*DATA_W-1:0]    wdata,
  input  logic [ADDR_BITS-1:0]        rd_addr,
  output logic [DATA_W-1:0]           rd_data
);

  localparam int DEPTH = 1 << ADDR_BITS;

  function automatic logic [DATA_W-1:0] merge_bits(
      input logic [DATA_W-1:0] old_w,
      input logic [DATA_W-1:0] new_w,
      input logic [DATA_W-1:0] sel);
    return (old_w & ~sel) | (new_w & sel);
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] port_word [NUM_WR];

  // Each port's final word already folds in every lower port that hits the
  // same address this cycle, so the last assignment in port order is exact.
  always_comb begin
    for (int p = 0; p < NUM_WR; p++) begin
      logic [DATA_W-1:0] acc;
      acc = mem[waddr[p*ADDR_BITS +: ADDR_BITS]];
      for (int q = 0; q < p; q++) begin
        if (waddr[q*ADDR_BITS +: ADDR_BITS] == waddr[p*ADDR_BITS +: ADDR_BITS])
          acc = merge_bits(acc, wdata[q*DATA_W +: DATA_W], wen[q*DATA_W +: DATA_W]);
      end
      port_word[p] = merge_bits(acc, wdata[p*DATA_W +: DATA_W], wen[p*DATA_W +: DATA_W]);
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_WR; p++) begin
      if (|wen[p*DATA_W +: DATA_W])
        mem[waddr[p*ADDR_BITS +: ADDR_BITS]] <= port_word[p];
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/emu_wport_ram.sv
module emu_wport_ram
  import emw_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                ADDR_BITS  = 4,
  parameter int                NUM_WR     = 2,
  parameter logic [NUM_WR-1:0] WR_POL     = 2'b01,
  parameter bit                RD_CLOCKED = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WR-1:0]           wr_clk_s,
  input  logic [NUM_WR*DATA_W-1:0]    wr_en,
  input  logic [NUM_WR*ADDR_BITS-1:0] wr_addr,
  input  logic [NUM_WR*DATA_W-1:0]    wr_data,
  input  logic [ADDR_BITS-1:0]        rd_addr,
  output logic [DATA_W-1:0]           rd_data
);

  if (RD_CLOCKED) begin : g_bad_read_cfg
    $error("emu_wport_ram: a registered read port cannot be built on the global clock");
  end

  // Named internal events, observed by the bound checker.
  logic [NUM_WR-1:0]           edge_hit;
  logic [NUM_WR*DATA_W-1:0]    gated_en;
  logic [NUM_WR*ADDR_BITS-1:0] staged_addr;
  logic [NUM_WR*DATA_W-1:0]    staged_data;

  for (genvar p = 0; p < NUM_WR; p++) begin : g_port
    emw_edge_det #(
      .POL (WR_POL[p] ? POL_RISE : POL_FALL)
    ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp    (wr_clk_s[p]),
      .edge_o (edge_hit[p])
    );

    emw_wr_stage #(
      .DATA_W    (DATA_W),
      .ADDR_BITS (ADDR_BITS)
    ) u_stage (
      .clk    (clk),
      .en_i   (wr_en[p*DATA_W +: DATA_W]),
      .addr_i (wr_addr[p*ADDR_BITS +: ADDR_BITS]),
      .data_i (wr_data[p*DATA_W +: DATA_W]),
      .edge_i (edge_hit[p]),
      .en_o   (gated_en[p*DATA_W +: DATA_W]),
      .addr_o (staged_addr[p*ADDR_BITS +: ADDR_BITS]),
      .data_o (staged_data[p*DATA_W +: DATA_W])
    );
  end

  emw_array #(
    .DATA_W    (DATA_W),
    .ADDR_BITS (ADDR_BITS),
    .NUM_WR    (NUM_WR)
  ) u_array (
    .clk     (clk),
    .wen     (gated_en),
    .waddr   (staged_addr),
    .wdata   (staged_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/emw_ram_checks.sv
module emw_ram_checks #(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_BITS = 4,
  parameter int                NUM_WR    = 2,
  parameter logic [NUM_WR-1:0] WR_POL    = 2'b01
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_WR-1:0]           wr_clk_s,
  input logic [NUM_WR*DATA_W-1:0]    wr_en,
  input logic [NUM_WR*ADDR_BITS-1:0] wr_addr,
  input logic [NUM_WR*DATA_W-1:0]    wr_data,
  input logic [ADDR_BITS-1:0]        rd_addr,
  input logic [DATA_W-1:0]           rd_data,
  input logic [NUM_WR-1:0]           edge_hit,
  input logic [NUM_WR*DATA_W-1:0]    gated_en,
  input logic [NUM_WR*ADDR_BITS-1:0] staged_addr,
  input logic [NUM_WR*DATA_W-1:0]    staged_data
);

  for (genvar p = 0; p < NUM_WR; p++) begin : g_chk
    if (WR_POL[p]) begin : g_rise
      // R2: a rising port reports an edge only on a 0->1 sample change
      p_rise_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit[p] |-> (wr_clk_s[p] && !$past(wr_clk_s[p])));
    end else begin : g_fall
      // R3: a falling port reports an edge only on a 1->0 sample change
      p_fall_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit[p] |-> (!wr_clk_s[p] && $past(wr_clk_s[p])));
    end

    // R4: a live write carries the port inputs of the previous global cycle
    p_stage_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gated_en[p*DATA_W +: DATA_W] != '0) |->
        ((gated_en[p*DATA_W +: DATA_W] == $past(wr_en[p*DATA_W +: DATA_W])) &&
         (staged_addr[p*ADDR_BITS +: ADDR_BITS] == $past(wr_addr[p*ADDR_BITS +: ADDR_BITS])) &&
         (staged_data[p*DATA_W +: DATA_W] == $past(wr_data[p*DATA_W +: DATA_W]))));
  end

  // R6: without any edge the word seen at a steady read address stays put
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit == '0) |=> ((rd_addr != $past(rd_addr)) || $stable(rd_data)));

endmodule

bind emu_wport_ram emw_ram_checks #(
  .DATA_W    (DATA_W),
  .ADDR_BITS (ADDR_BITS),
  .NUM_WR    (NUM_WR),
  .WR_POL    (WR_POL)
) u_emw_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_clk_s    (wr_clk_s),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .edge_hit    (edge_hit),
  .gated_en    (gated_en),
  .staged_addr (staged_addr),
  .staged_data (staged_data)
);

// File: tb/emu_wport_ram_test.sv
`timescale 1ns/1ps
module emu_wport_ram_test;

  localparam int W  = 8;
  localparam int A  = 4;
  localparam int NW = 2;
  localparam int DEPTH = 1 << A;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NW-1:0]     wclk = '0;
  logic [NW*W-1:0]   en = '0;
  logic [NW*A-1:0]   addr = '0;
  logic [NW*W-1:0]   data = '0;
  logic [A-1:0]      rd_addr = '0;
  logic [W-1:0]      rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [W-1:0] model [DEPTH];

  typedef struct {
    logic [A-1:0] a;
    logic [W-1:0] exp;
    string        tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  // port 0 rising, port 1 falling
  emu_wport_ram #(.DATA_W(W), .ADDR_BITS(A), .NUM_WR(NW), .WR_POL(2'b01)) uut (
    .clk(clk), .rst_n(rst_n), .wr_clk_s(wclk), .wr_en(en), .wr_addr(addr),
    .wr_data(data), .rd_addr(rd_addr), .rd_data(rd_data));

  // monitor: pops expected items, presents the address, compares the same cycle
  initial begin
    forever begin
      item_t it;
      @(negedge clk);
      if (sb.size() > 0) begin
        it = sb.pop_front();
        rd_addr = it.a;
        #1;
        n_tests++;
        if (rd_data !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr %0d actual %h expected %h", it.tag, it.a, rd_data, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_port(input int p, input logic [W-1:0] e,
                          input logic [A-1:0] a, input logic [W-1:0] d);
    en[p*W +: W]   = e;
    addr[p*A +: A] = a;
    data[p*W +: W] = d;
  endtask

  // slow-clock model: the word takes the enabled bits on the emulated edge
  task automatic mwrite(input logic [W-1:0] e, input logic [A-1:0] a,
                        input logic [W-1:0] d);
    model[a] = (model[a] & ~e) | (d & e);
  endtask

  task automatic expect_one(input logic [A-1:0] a, input string tag);
    item_t it;
    it.a = a; it.exp = model[a]; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drain;
    wait (sb.size() == 0);
    tick(1);
  endtask

  // write through rising port 0
  task automatic wr0(input logic [W-1:0] e, input logic [A-1:0] a, input logic [W-1:0] d);
    set_port(0, e, a, d);
    wclk[0] = 1'b0;
    tick(2);
    wclk[0] = 1'b1;
    tick(2);
    mwrite(e, a, d);
    wclk[0] = 1'b0;
    tick(2);
  endtask

  // write through falling port 1
  task automatic wr1(input logic [W-1:0] e, input logic [A-1:0] a, input logic [W-1:0] d);
    set_port(1, e, a, d);
    wclk[1] = 1'b1;
    tick(2);
    wclk[1] = 1'b0;
    tick(2);
    mwrite(e, a, d);
    wclk[1] = 1'b1;
    tick(2);
  endtask

  initial begin
    rst_n = 1'b0;
    wclk  = 2'b01;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    wclk[1] = 1'b1;
    tick(2);

    // R1: fill the whole array through port 0, read every word back
    for (int i = 0; i < DEPTH; i++) wr0(8'hFF, A'(i), W'((i * 37 + 11) ^ 8'h5A));
    for (int i = 0; i < DEPTH; i++) expect_one(A'(i), "R1 fill readback");
    drain();

    // R7: reset with write clocks parked at the reset levels and enables live
    set_port(0, 8'hFF, 4'd3, 8'h00);
    set_port(1, 8'hFF, 4'd3, 8'hFF);
    rst_n = 1'b0;
    wclk  = 2'b01;
    tick(2);
    wclk  = 2'b00;
    tick(1);
    wclk  = 2'b01;
    tick(2);
    rst_n = 1'b1;
    tick(4);
    expect_one(4'd3, "R7 no write across reset");
    drain();

    // R2: rising port sees 1->0, then R3: falling port sees 0->1: no writes
    wclk[0] = 1'b0;
    tick(3);
    expect_one(4'd3, "R2 falling change on rising port");
    drain();
    wclk[1] = 1'b1;
    tick(3);
    expect_one(4'd3, "R3 rising change on falling port");
    drain();

    // R6: enables on, inputs moving, clocks still
    for (int i = 0; i < 8; i++) begin
      set_port(0, 8'hFF, A'(i), 8'h33 + W'(i));
      set_port(1, 8'hFF, A'(i + 8), 8'hC0 + W'(i));
      tick(1);
    end
    tick(2);
    for (int i = 0; i < DEPTH; i++) expect_one(A'(i), "R6 idle clocks");
    drain();

    // R3: writes through the falling port
    wr1(8'hFF, 4'd5, 8'hA5);
    wr1(8'hFF, 4'd12, 8'h3C);
    expect_one(4'd5, "R3 falling write");
    expect_one(4'd12, "R3 falling write");
    drain();

    // R5: partial enables on both ports
    wr0(8'h0F, 4'd7, 8'hEE);
    wr1(8'hA0, 4'd9, 8'h55);
    expect_one(4'd7, "R5 low nibble enable");
    expect_one(4'd9, "R5 sparse enable");
    drain();

    // R4: inputs change together with the edge sample; old values must win
    set_port(0, 8'hFF, 4'd2, 8'h81);
    wclk[0] = 1'b0;
    tick(2);
    wclk[0] = 1'b1;
    set_port(0, 8'hFF, 4'd4, 8'h7E);
    tick(2);
    mwrite(8'hFF, 4'd2, 8'h81);
    wclk[0] = 1'b0;
    tick(2);
    expect_one(4'd2, "R4 staged address and data");
    expect_one(4'd4, "R4 late values unused");
    drain();

    // R8: both ports, opposite polarities, same address, same edge cycle
    set_port(0, 8'hFF, 4'd10, 8'h12);
    set_port(1, 8'hF0, 4'd10, 8'hBC);
    wclk = 2'b10;
    tick(2);
    wclk = 2'b01;
    tick(2);
    mwrite(8'hFF, 4'd10, 8'h12);
    mwrite(8'hF0, 4'd10, 8'hBC);
    wclk = 2'b10;
    tick(2);
    expect_one(4'd10, "R8 higher port wins overlap");
    drain();

    // R8: overlap on a single bit only
    set_port(0, 8'h18, 4'd11, 8'hFF);
    set_port(1, 8'h30, 4'd11, 8'h00);
    wclk = 2'b10;
    tick(2);
    wclk = 2'b01;
    tick(2);
    mwrite(8'h18, 4'd11, 8'hFF);
    mwrite(8'h30, 4'd11, 8'h00);
    wclk = 2'b10;
    tick(2);
    expect_one(4'd11, "R8 partial overlap");
    drain();

    // R1: read address sweep after all traffic
    for (int i = DEPTH - 1; i >= 0; i--) expect_one(A'(i), "R1 final sweep");
    drain();

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule